// File: doc/BRIEF.md
# Block-Mode Transfer Engine

This block copies data from one memory region to another, one complete block for each trigger pulse. One of the two sides, chosen at configuration time, is the block area. Within a block, its address steps in its own programmed direction. When the block ends, that address and the unit counter go back to their starting values. The address on the other side keeps moving from block to block, so repeated triggers can gather a fixed buffer into a long stream, or scatter a stream into a fixed buffer.

Software loads a configuration through a single-cycle load strobe. It sets both start addresses, both step modes, which side is the block area, the unit size, the block size and the number of blocks. Each trigger then moves one block over a single-beat valid/ready memory port. Every unit is one read from the source followed by one write to the destination. After the programmed number of blocks, an interrupt line is raised and stays high until it is cleared.

Top module: `blkxfer_engine`

## Requirements
- R1: After reset, `irq`, `busy` and `mem_req_valid` are low, and no request is issued until a configuration has been loaded and a trigger arrives.
- R2: Each unit is a read at the current source address, followed by a write of the read data to the current destination address. The next unit's read is not issued before the write handshake completes. `cfg_word`=1 selects 16-bit units (address step 2, little-endian); `cfg_word`=0 selects 8-bit units (step 1, data in bits 7:0).
- R3: Each side's 2-bit mode field selects 00 fixed, 01 increment, 10 decrement, 11 fixed. Inside a block, the block-area address also follows its own mode.
- R4: `cfg_blk_dst`=0 makes the source the block area; `cfg_blk_dst`=1 makes the destination the block area. At the end of every block, the block-area address and the unit counter return to their loaded values.
- R5: The address of the side that is not the block area keeps its stepped value from one block to the next.
- R6: The block-size field gives the number of units per block. The value 0 means 2^SZW (256 at default), and any other value is taken literally.
- R7: Each accepted trigger moves exactly one block. The block-count field gives the number of blocks, and the value 0 means 2^CNTW.
- R8: `irq` rises in the cycle after the final write handshake of the last block, not earlier. It then stays high until `irq_clr` is pulsed.
- R9: A trigger that arrives while a block is in progress is ignored.
- R10: After the last block, triggers are ignored until a new configuration is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load strobe for all cfg_* fields; taken only while idle |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_src_mode | input | 2 | Source step mode |
| cfg_dst_mode | input | 2 | Destination step mode |
| cfg_blk_dst | input | 1 | 1: destination is the block area, 0: source is |
| cfg_word | input | 1 | 1: 16-bit units, 0: 8-bit units |
| cfg_blk_size | input | SZW | Units per block, 0 means 2^SZW |
| cfg_blk_count | input | CNTW | Number of blocks, 0 means 2^CNTW |
| trig | input | 1 | Starts one block |
| irq_clr | input | 1 | Clears the interrupt |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1: write, 0: read |
| mem_req_word | output | 1 | Access is 16-bit |
| mem_req_addr | output | AW | Access address |
| mem_req_wdata | output | DW | Write data |
| mem_req_ready | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | A block is in progress |
| irq | output | 1 | All programmed blocks have finished |

## Verification
The bench builds the engine with AW=12, DW=16, SZW=8 and CNTW=4. The 12-bit address keeps the bench memory at 4 KiB. With SZW left at 8, a full 256-unit block, selected by the zero encoding, completes in well under a thousand cycles. Shrinking CNTW to 4 makes the zero-encoded maximum block count equal to 16. The full wrap of the block counter, with the interrupt held back until the sixteenth block, can then be observed directly.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } xfer_state_e;

    typedef enum logic [1:0] {
        AM_FIXED = 2'b00,
        AM_INC   = 2'b01,
        AM_DEC   = 2'b10,
        AM_HOLD  = 2'b11
    } addr_mode_e;

endpackage

// File: rtl/blkxfer_addr_unit.sv
module blkxfer_addr_unit
    import blkxfer_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [1:0]    load_mode,
    input  logic          word,
    input  logic          step,
    input  logic          restore,
    output logic [AW-1:0] addr
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] cur;
        logic [1:0]    mode;
    } au_regs_t;

    au_regs_t r_q, r_d;
    logic [AW-1:0] step_amt;

    assign step_amt = {{(AW-2){1'b0}}, word, ~word};

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.base = load_addr;
            r_d.cur  = load_addr;
            r_d.mode = load_mode;
        end else if (restore) begin
            r_d.cur = r_q.base;
        end else if (step) begin
            case (addr_mode_e'(r_q.mode))
                AM_INC:  r_d.cur = r_q.cur + step_amt;
                AM_DEC:  r_d.cur = r_q.cur - step_amt;
                default: r_d.cur = r_q.cur;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr = r_q.cur;

    // R3: a fixed-mode pointer never moves unless reloaded
    a_r3_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (r_q.mode[0] == r_q.mode[1])) |=> $stable(r_q.cur));

    // R4: restore brings the pointer back to its loaded base
    a_r4_restore_base: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !load) |=> (r_q.cur == $past(r_q.base)));

endmodule

// File: rtl/blkxfer_count_unit.sv
module blkxfer_count_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic         restore,
    output logic         last
);

    typedef struct packed {
        logic [W-1:0] reload;
        logic [W-1:0] cnt;
    } cu_regs_t;

    cu_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.reload = load_val;
            r_d.cnt    = load_val;
        end else if (restore) begin
            r_d.cnt = r_q.reload;
        end else if (dec) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // A count of zero is the wrapped maximum, so only one means "last"
    assign last = (r_q.cnt == W'(1));

    // R6: the reload value is never disturbed by counting
    a_r6_reload_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(r_q.reload));

    // R4: after a restore the counter holds the reload value
    a_r4_count_restored: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !load) |=> (r_q.cnt == r_q.reload));

endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine
    import blkxfer_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int SZW  = 8,
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_load,
    input  logic [AW-1:0]   cfg_src_addr,
    input  logic [AW-1:0]   cfg_dst_addr,
    input  logic [1:0]      cfg_src_mode,
    input  logic [1:0]      cfg_dst_mode,
    input  logic            cfg_blk_dst,
    input  logic            cfg_word,
    input  logic [SZW-1:0]  cfg_blk_size,
    input  logic [CNTW-1:0] cfg_blk_count,
    input  logic            trig,
    input  logic            irq_clr,
    output logic            mem_req_valid,
    output logic            mem_req_write,
    output logic            mem_req_word,
    output logic [AW-1:0]   mem_req_addr,
    output logic [DW-1:0]   mem_req_wdata,
    input  logic            mem_req_ready,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            irq
);

    localparam int NSIDE   = 2;
    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;

    typedef struct packed {
        xfer_state_e   state;
        logic [DW-1:0] data;
        logic          word;
        logic          blk_dst;
        logic          armed;
        logic          irq;
    } eng_regs_t;

    eng_regs_t r_q, r_d;

    logic load_ok, fire, rd_hs, wr_hs;
    logic unit_last, blk_last, blk_done, all_done;

    logic [AW-1:0] side_load_addr [NSIDE];
    logic [1:0]    side_load_mode [NSIDE];
    logic          side_restore   [NSIDE];
    logic [AW-1:0] side_addr      [NSIDE];

    assign load_ok  = cfg_load && (r_q.state == ST_IDLE);
    assign fire     = trig && (r_q.state == ST_IDLE) && r_q.armed && !load_ok;
    assign rd_hs    = (r_q.state == ST_READ)  && mem_req_ready;
    assign wr_hs    = (r_q.state == ST_WRITE) && mem_req_ready;
    assign blk_done = wr_hs && unit_last;
    assign all_done = blk_done && blk_last;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (fire) r_d.state = ST_READ;
            end
            ST_READ: begin
                if (rd_hs) begin
                    r_d.data  = r_q.word ? mem_rdata
                                         : {{(DW-8){1'b0}}, mem_rdata[7:0]};
                    r_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (wr_hs) r_d.state = unit_last ? ST_IDLE : ST_READ;
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (load_ok) begin
            r_d.word    = cfg_word;
            r_d.blk_dst = cfg_blk_dst;
            r_d.armed   = 1'b1;
        end else if (all_done) begin
            r_d.armed = 1'b0;
        end

        if (all_done)     r_d.irq = 1'b1;
        else if (irq_clr) r_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign side_load_addr[SIDE_SRC] = cfg_src_addr;
    assign side_load_addr[SIDE_DST] = cfg_dst_addr;
    assign side_load_mode[SIDE_SRC] = cfg_src_mode;
    assign side_load_mode[SIDE_DST] = cfg_dst_mode;
    assign side_restore[SIDE_SRC]   = blk_done && !r_q.blk_dst;
    assign side_restore[SIDE_DST]   = blk_done &&  r_q.blk_dst;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        blkxfer_addr_unit #(.AW(AW)) u_addr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_ok),
            .load_addr (side_load_addr[g]),
            .load_mode (side_load_mode[g]),
            .word      (r_q.word),
            .step      (wr_hs),
            .restore   (side_restore[g]),
            .addr      (side_addr[g])
        );
    end

    blkxfer_count_unit #(.W(SZW)) u_unit_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (cfg_blk_size),
        .dec      (wr_hs),
        .restore  (blk_done),
        .last     (unit_last)
    );

    blkxfer_count_unit #(.W(CNTW)) u_blk_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (cfg_blk_count),
        .dec      (blk_done),
        .restore  (1'b0),
        .last     (blk_last)
    );

    assign mem_req_valid = (r_q.state != ST_IDLE);
    assign mem_req_write = (r_q.state == ST_WRITE);
    assign mem_req_word  = r_q.word;
    assign mem_req_addr  = mem_req_write ? side_addr[SIDE_DST] : side_addr[SIDE_SRC];
    assign mem_req_wdata = r_q.data;
    assign busy          = (r_q.state != ST_IDLE);
    assign irq           = r_q.irq;

    // R2: a pending request keeps its address and direction
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R2: an accepted read is followed by a write
    a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write && mem_req_ready) |=>
            (mem_req_valid && mem_req_write));

    // R8: the interrupt stays up until cleared
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R8: the interrupt rises only after an accepted write
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req_valid && mem_req_write && mem_req_ready));

    // R10: once disarmed, the engine stays idle until reloaded
    a_r10_disarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.armed && !busy) |=> !busy);

endmodule

// File: tb/blkxfer_engine_bench.sv
module blkxfer_engine_bench;

    localparam int AW   = 12;
    localparam int DW   = 16;
    localparam int SZW  = 8;
    localparam int CNTW = 4;
    localparam int MEMN = 1 << AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_load = 1'b0;
    logic [AW-1:0]   cfg_src_addr = '0;
    logic [AW-1:0]   cfg_dst_addr = '0;
    logic [1:0]      cfg_src_mode = '0;
    logic [1:0]      cfg_dst_mode = '0;
    logic            cfg_blk_dst = 1'b0;
    logic            cfg_word = 1'b0;
    logic [SZW-1:0]  cfg_blk_size = '0;
    logic [CNTW-1:0] cfg_blk_count = '0;
    logic            trig = 1'b0;
    logic            irq_clr = 1'b0;
    logic            mem_req_valid, mem_req_write, mem_req_word;
    logic [AW-1:0]   mem_req_addr;
    logic [DW-1:0]   mem_req_wdata;
    logic            mem_req_ready = 1'b0;
    logic [DW-1:0]   mem_rdata;
    logic            busy, irq;

    logic [7:0] mem [MEMN];
    int n_checks = 0;
    int n_fail   = 0;
    int stall    = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    blkxfer_engine #(.AW(AW), .DW(DW), .SZW(SZW), .CNTW(CNTW)) u_blkxfer_engine (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_blk_dst(cfg_blk_dst), .cfg_word(cfg_word),
        .cfg_blk_size(cfg_blk_size), .cfg_blk_count(cfg_blk_count),
        .trig(trig), .irq_clr(irq_clr),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_word(mem_req_word), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_ready(mem_req_ready),
        .mem_rdata(mem_rdata), .busy(busy), .irq(irq)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // Memory model: little-endian, ready stalls one cycle in three
    assign mem_rdata = {mem[mem_req_addr + AW'(1)], mem[mem_req_addr]};

    always @(negedge clk) begin
        stall <= stall + 1;
        mem_req_ready <= ((stall % 3) != 2);
    end

    always @(posedge clk) begin
        if (mem_req_valid && mem_req_ready && mem_req_write) begin
            mem[mem_req_addr] <= mem_req_wdata[7:0];
            if (mem_req_word) mem[mem_req_addr + AW'(1)] <= mem_req_wdata[15:8];
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < MEMN; i++) mem[i] = pat(i);
    endtask

    task automatic clear_irq();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
    endtask

    task automatic load(input int src, input int dst, input int sm, input int dm,
                        input bit bdst, input bit wd, input int sz, input int cnt);
        @(negedge clk);
        cfg_src_addr  = AW'(src);
        cfg_dst_addr  = AW'(dst);
        cfg_src_mode  = 2'(sm);
        cfg_dst_mode  = 2'(dm);
        cfg_blk_dst   = bdst;
        cfg_word      = wd;
        cfg_blk_size  = SZW'(sz);
        cfg_blk_count = CNTW'(cnt);
        cfg_load      = 1'b1;
        @(negedge clk) cfg_load = 1'b0;
    endtask

    task automatic run_block();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 irq", irq, 0);
        chk("R1 busy", busy, 0);
        chk("R1 valid", mem_req_valid, 0);
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        @(negedge clk);
        chk("R1 no start before load", busy, 0);
    endtask

    // R4 R5 R7 R8: source block area, three blocks into a running destination
    task automatic t_src_block();
        int bad = 0;
        init_mem(); clear_irq();
        load(12'h100, 12'h200, 1, 1, 1'b0, 1'b0, 4, 3);
        run_block(); chk("R8 no irq after block 1", irq, 0);
        run_block(); chk("R8 no irq after block 2", irq, 0);
        run_block(); chk("R8 irq after last block", irq, 1);
        for (int i = 0; i < 12; i++) if (mem[12'h200 + i] != pat(12'h100 + i % 4)) bad++;
        chk("R4 R5 src block copies", bad, 0);
        chk("R7 no extra unit", mem[12'h20C], pat(12'h20C));
    endtask

    // R2 R4 R5: word units, destination block area overwritten each block
    task automatic t_dst_block_word();
        int bad = 0;
        init_mem(); clear_irq();
        load(12'h080, 12'h300, 1, 1, 1'b1, 1'b1, 3, 2);
        run_block(); run_block();
        for (int i = 0; i < 6; i++) if (mem[12'h300 + i] != pat(12'h086 + i)) bad++;
        chk("R2 R5 word stream into dst block", bad, 0);
        chk("R4 dst block end", mem[12'h306], pat(12'h306));
        chk("R8 irq", irq, 1);
    endtask

    // R3: decrementing block area
    task automatic t_decrement();
        int bad = 0;
        init_mem(); clear_irq();
        load(12'h13F, 12'h240, 2, 1, 1'b0, 1'b0, 4, 1);
        run_block();
        for (int i = 0; i < 4; i++) if (mem[12'h240 + i] != pat(12'h13F - i)) bad++;
        chk("R3 decrement order", bad, 0);
    endtask

    // R3: fixed destination (mode 11) keeps only the last unit
    task automatic t_fixed();
        init_mem(); clear_irq();
        load(12'h150, 12'h260, 1, 3, 1'b0, 1'b0, 4, 1);
        run_block();
        chk("R3 fixed dst last unit", mem[12'h260], pat(12'h153));
        chk("R3 fixed dst neighbour", mem[12'h261], pat(12'h261));
    endtask

    // R6: size 0 means 256 units
    task automatic t_size_max();
        int bad = 0;
        init_mem(); clear_irq();
        load(12'h000, 12'h400, 1, 1, 1'b0, 1'b0, 0, 1);
        run_block();
        for (int i = 0; i < 256; i++) if (mem[12'h400 + i] != pat(i)) bad++;
        chk("R6 256-unit block", bad, 0);
        chk("R6 stops at 256", mem[12'h500], pat(12'h500));
    endtask

    // R7: count 0 means 16 blocks here
    task automatic t_count_max();
        int bad = 0;
        init_mem(); clear_irq();
        load(12'h010, 12'h600, 0, 1, 1'b0, 1'b0, 1, 0);
        for (int b = 0; b < 15; b++) run_block();
        chk("R7 no irq after 15 blocks", irq, 0);
        run_block();
        chk("R7 irq after 16 blocks", irq, 1);
        for (int i = 0; i < 16; i++) if (mem[12'h600 + i] != pat(12'h010)) bad++;
        chk("R7 16 units written", bad, 0);
        chk("R7 no 17th block", mem[12'h610], pat(12'h610));
    endtask

    // R9 R10 R8: busy trigger ignored, post-completion trigger ignored, clear
    task automatic t_triggers();
        int bad = 0;
        int seen = 0;
        init_mem(); clear_irq();
        load(12'h020, 12'h700, 1, 1, 1'b0, 1'b0, 4, 2);
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        @(negedge clk);
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 busy trigger dropped: idle", busy, 0);
        chk("R9 busy trigger dropped: irq", irq, 0);
        chk("R9 second block not run", mem[12'h704], pat(12'h704));
        run_block();
        for (int i = 0; i < 4; i++) if (mem[12'h704 + i] != pat(12'h020 + i)) bad++;
        chk("R9 second block on real trigger", bad, 0);
        chk("R8 irq set", irq, 1);
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (mem_req_valid) seen++;
        end
        chk("R10 trigger after last ignored", seen, 0);
        chk("R10 memory untouched", mem[12'h708], pat(12'h708));
        chk("R8 irq held", irq, 1);
        clear_irq();
        chk("R8 irq cleared", irq, 0);
    endtask

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_src_block();
        t_dst_block_word();
        t_decrement();
        t_fixed();
        t_size_max();
        t_count_max();
        t_triggers();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule